// File: doc/BRIEF.md
# I2C SCL Clock Divider Generator

This block produces the SCL timing for an I2C master. It divides a fast system clock by a 12-bit divider value and uses a separate mode bit to pick standard or fast timing. The divider arrives as two fields that are written independently: a 7-bit low part and a 5-bit upper part. The block drives one SCL low-drive request. It also gives single-cycle strobes that mark the start of each low phase, the moment SCL is seen high, and the middle of the high phase. START and STOP generation, byte shifting and arbitration sit in neighbouring logic, and that logic uses these strobes.

The period depends on the mode, and each mode adds a fixed number of overhead cycles. Standard timing gives a period of 2*(CC-1)+7 system cycles. Fast timing gives 3*(CC-1)+9 cycles. Fast timing is meant for bus rates above 100 kHz, up to 400 kHz. The divider value and mode are captured only when a new period begins. The high phase counts only those cycles in which the sampled SCL line is high, so a target that holds SCL low stretches the clock. A divider value below 3 is rejected: SCL stays released and an error flag is raised.

Top module: `scl_clkgen`

## Requirements
- R1: The divider value CC is {div_hi, div_lo}: div_lo supplies bits [6:0] and div_hi supplies bits [11:7].
- R2: With fast_sel = 0 and no stretching, consecutive tick_fall strobes are 2*(CC-1)+7 cycles apart.
- R3: With fast_sel = 1 and no stretching, consecutive tick_fall strobes are 3*(CC-1)+9 cycles apart.
- R4: In standard mode, scl_drive_low is high for CC+3 cycles and released for CC+2 cycles, so the odd cycle goes to the low phase.
- R5: In fast mode, the low phase lasts 2*(CC+2) cycles and the high phase lasts CC+2 cycles.
- R6: While CC < 3 and en = 1, no new period starts: SCL stays released, no tick_fall occurs, and cfg_err is high one cycle after the illegal value is applied.
- R7: The high phase advances only on cycles where scl_in = 1. Each cycle in which SCL is held low after release lengthens the period and delays tick_rise and tick_mid by one cycle.
- R8: When en = 0, scl_drive_low is 0 in the following cycle and no strobe occurs. When en rises with a legal divider, tick_fall and scl_drive_low are both high in the next cycle.
- R9: A change to div_lo, div_hi or fast_sel during a period does not alter that period. It applies from the next period.
- R10: tick_fall is high in the first low cycle. tick_rise is high one cycle after the first high-phase cycle with scl_in = 1. tick_mid is high one cycle after the high-phase cycle whose count index equals floor(high length / 2). Each strobe fires once per period, and no two strobes are high together.
- R11: During and right after reset, scl_drive_low, all strobes and cfg_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low releases SCL and clears counters |
| div_lo | input | 7 | Divider bits [6:0] |
| div_hi | input | 5 | Divider bits [11:7] |
| fast_sel | input | 1 | 1 = fast timing, 0 = standard timing |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | Request to pull SCL low |
| tick_fall | output | 1 | Strobe at the first cycle of the low phase |
| tick_rise | output | 1 | Strobe marking SCL seen high |
| tick_mid | output | 1 | Strobe at mid high phase |
| cfg_err | output | 1 | Divider value below minimum while enabled |

## Verification
The hardest case to reach from the ports is a divider or mode change that lands inside a period that is already running. This matters most when the change coincides with a stretched high phase, because then the old lengths must still finish the current period. The bench models the SCL wire as the inverse of the drive request, combined with a hold-low term under bench control. It writes new divider fields a few cycles after a fall strobe and holds SCL low for a chosen number of cycles after release. It then checks the length of the interrupted period against the old setting and the following period against the new one. Random divider and mode pairs, with random stretch lengths, cover the remaining space.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

endpackage

// File: rtl/scl_div_decode.sv
module scl_div_decode #(
  parameter int LO_W    = 7,
  parameter int HI_W    = 5,
  parameter int MIN_DIV = 3,
  parameter int CNT_W   = LO_W + HI_W + 3
) (
  input  logic [LO_W-1:0]  div_lo,
  input  logic [HI_W-1:0]  div_hi,
  input  logic             fast_sel,
  output logic             legal,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] high_len
);
  localparam int DIV_W = LO_W + HI_W;

  logic [DIV_W-1:0] cc;
  logic [CNT_W-1:0] base;

  always_comb begin
    cc    = {div_hi, div_lo};
    legal = (cc >= DIV_W'(MIN_DIV));
    // both modes share a high phase of CC+2 cycles
    base     = CNT_W'(cc) + CNT_W'(2);
    high_len = base;
    // fast: low is twice high; standard: low takes the odd extra cycle
    low_len  = fast_sel ? (base << 1) : (base + CNT_W'(1));
  end

endmodule

// File: rtl/scl_len_hold.sv
module scl_len_hold #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] low_in,
  input  logic [CNT_W-1:0] high_in,
  output logic [CNT_W-1:0] low_q,
  output logic [CNT_W-1:0] high_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (load) begin
      low_q  <= low_in;
      high_q <= high_in;
    end
  end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_clkgen_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             legal,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  input  logic             scl_in,
  output logic             load,
  output logic             drive_low,
  output logic             tick_fall,
  output logic             tick_rise,
  output logic             tick_mid
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_ok;
  logic             rise_d, mid_d;

  always_comb begin
    start_ok = en && legal;
    state_d  = state_q;
    cnt_d    = cnt_q;
    unique case (state_q)
      PH_IDLE: begin
        if (start_ok) begin
          state_d = PH_LOW;
          cnt_d   = '0;
        end
      end
      PH_LOW: begin
        if (cnt_q == low_len - ONE) begin
          state_d = PH_HIGH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      PH_HIGH: begin
        // counting stalls while a target holds the line low
        if (scl_in) begin
          if (cnt_q == high_len - ONE) begin
            state_d = start_ok ? PH_LOW : PH_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      default: begin
        state_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
    if (!en) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
    end
    load   = (state_d == PH_LOW) && (state_q != PH_LOW);
    rise_d = (state_q == PH_HIGH) && scl_in && (cnt_q == '0);
    mid_d  = (state_q == PH_HIGH) && scl_in && (cnt_q == (high_len >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PH_IDLE;
      cnt_q     <= '0;
      drive_low <= 1'b0;
      tick_fall <= 1'b0;
      tick_rise <= 1'b0;
      tick_mid  <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      drive_low <= (state_d == PH_LOW);
      tick_fall <= load;
      tick_rise <= rise_d && en;
      tick_mid  <= mid_d && en;
    end
  end

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int LO_W    = 7,
  parameter int HI_W    = 5,
  parameter int MIN_DIV = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [LO_W-1:0] div_lo,
  input  logic [HI_W-1:0] div_hi,
  input  logic            fast_sel,
  input  logic            scl_in,
  output logic            scl_drive_low,
  output logic            tick_fall,
  output logic            tick_rise,
  output logic            tick_mid,
  output logic            cfg_err
);
  localparam int DIV_W = LO_W + HI_W;
  localparam int CNT_W = DIV_W + 3;

  logic             legal;
  logic             load;
  logic [CNT_W-1:0] low_live, high_live;
  logic [CNT_W-1:0] low_hold, high_hold;
  logic [CNT_W-1:0] low_use, high_use;

  scl_div_decode #(
    .LO_W(LO_W), .HI_W(HI_W), .MIN_DIV(MIN_DIV), .CNT_W(CNT_W)
  ) u_decode (
    .div_lo  (div_lo),
    .div_hi  (div_hi),
    .fast_sel(fast_sel),
    .legal   (legal),
    .low_len (low_live),
    .high_len(high_live)
  );

  scl_len_hold #(.CNT_W(CNT_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .low_in (low_live),
    .high_in(high_live),
    .low_q  (low_hold),
    .high_q (high_hold)
  );

  // lengths in force for the running period are the captured ones
  assign low_use  = low_hold;
  assign high_use = high_hold;

  scl_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .legal    (legal),
    .low_len  (low_use),
    .high_len (high_use),
    .scl_in   (scl_in),
    .load     (load),
    .drive_low(scl_drive_low),
    .tick_fall(tick_fall),
    .tick_rise(tick_rise),
    .tick_mid (tick_mid)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= en && !legal;
  end

endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
  parameter int LO_W    = 7,
  parameter int HI_W    = 5,
  parameter int MIN_DIV = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic [LO_W-1:0] div_lo,
  input logic [HI_W-1:0] div_hi,
  input logic            scl_in,
  input logic            scl_drive_low,
  input logic            tick_fall,
  input logic            tick_rise,
  input logic            tick_mid,
  input logic            cfg_err
);
  localparam int DIV_W = LO_W + HI_W;

  logic small_div;
  assign small_div = ({div_hi, div_lo} < DIV_W'(MIN_DIV));

  p_ticks_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tick_fall, tick_rise, tick_mid}));

  p_fall_in_low_r10: assert property (@(posedge clk) disable iff (rst)
    tick_fall |-> scl_drive_low);

  p_rise_seen_high_r7: assert property (@(posedge clk) disable iff (rst)
    tick_rise |-> (!scl_drive_low && $past(scl_in)));

  p_mid_released_r10: assert property (@(posedge clk) disable iff (rst)
    tick_mid |-> !scl_drive_low);

  p_disable_releases_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_drive_low && !tick_fall && !tick_rise && !tick_mid));

  p_small_div_no_start_r6: assert property (@(posedge clk) disable iff (rst)
    (en && small_div) |=> !tick_fall);

  p_err_no_start_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !tick_fall);

endmodule

bind scl_clkgen scl_clkgen_chk #(
  .LO_W(LO_W), .HI_W(HI_W), .MIN_DIV(MIN_DIV)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .en           (en),
  .div_lo       (div_lo),
  .div_hi       (div_hi),
  .scl_in       (scl_in),
  .scl_drive_low(scl_drive_low),
  .tick_fall    (tick_fall),
  .tick_rise    (tick_rise),
  .tick_mid     (tick_mid),
  .cfg_err      (cfg_err)
);

// File: tb/tb_scl_clkgen.sv
`timescale 1ns/1ps
module tb_scl_clkgen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [6:0] div_lo = '0;
  logic [4:0] div_hi = '0;
  logic       fast_sel = 1'b0;
  logic       hold = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, tick_fall, tick_rise, tick_mid, cfg_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // open-drain wire: low when the block pulls or a target holds it
  assign scl_in = ~scl_drive_low & ~hold;

  scl_clkgen dut (
    .clk(clk), .rst(rst), .en(en), .div_lo(div_lo), .div_hi(div_hi),
    .fast_sel(fast_sel), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .tick_fall(tick_fall), .tick_rise(tick_rise), .tick_mid(tick_mid),
    .cfg_err(cfg_err)
  );

  function automatic int exp_low(input bit fast, input int cc);
    return fast ? 2 * (cc + 2) : cc + 3;
  endfunction

  function automatic int exp_high(input int cc);
    return cc + 2;
  endfunction

  function automatic int exp_period(input bit fast, input int cc);
    return fast ? 3 * (cc - 1) + 9 : 2 * (cc - 1) + 7;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic set_cfg(input bit fast, input int cc);
    fast_sel = fast;
    div_lo   = cc[6:0];
    div_hi   = cc[11:7];
  endtask

  // Measures one period starting at a fall strobe. Optional stretch S and
  // optional reconfiguration two cycles into the period.
  task automatic measure(input bit do_chk, input bit fast, input int cc, input int s,
                         input bit swap, input bit nfast, input int ncc, input string req);
    int guard = 0;
    int k = 0;
    int lm = -1, rm = -1, mm = -1, nr = 0, nm = 0;
    int el, eh;
    el = exp_low(fast, cc);
    eh = exp_high(cc);
    while (!tick_fall && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (!tick_fall) begin
      chk(1'b0, {req, " no fall strobe"}, 0, 1);
      return;
    end
    hold = (s > 0);
    do begin
      @(negedge clk);
      k++;
      if (swap && k == 2) set_cfg(nfast, ncc);
      if (lm < 0 && !scl_drive_low) lm = k;
      if (tick_rise) begin if (rm < 0) rm = k; nr++; end
      if (tick_mid) begin if (mm < 0) mm = k; nm++; end
      if (s > 0 && k == el + s) hold = 1'b0;
    end while (!tick_fall && k < 20000);
    hold = 1'b0;
    if (do_chk) begin
      chk(k == exp_period(fast, cc) + s, {req, " period"}, k, exp_period(fast, cc) + s);
      chk(lm == el, {req, " low length"}, lm, el);
      chk(rm == el + s + 1, {req, " R10 rise offset"}, rm, el + s + 1);
      chk(mm == el + s + (eh >> 1) + 1, {req, " R10 mid offset"}, mm, el + s + (eh >> 1) + 1);
      chk(nr == 1 && nm == 1, {req, " R10 one strobe each"}, nr * 10 + nm, 11);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed_v;
    int quiet;
    seed_v = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!scl_drive_low && !tick_fall && !tick_rise && !tick_mid && !cfg_err,
        "R11 reset outputs", {scl_drive_low, tick_fall, tick_rise, tick_mid, cfg_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!scl_drive_low && !cfg_err, "R11 after reset", {scl_drive_low, cfg_err}, 0);

    // R8: start on enable, minimum legal divider, standard (R2, R4)
    set_cfg(1'b0, 3);
    en = 1'b1;
    @(negedge clk);
    chk(tick_fall && scl_drive_low, "R8 start strobe", {tick_fall, scl_drive_low}, 3);
    measure(1'b1, 1'b0, 3, 0, 1'b0, 1'b0, 0, "R2 R4 std cc3");
    measure(1'b1, 1'b0, 3, 0, 1'b0, 1'b0, 0, "R2 R4 std cc3 again");

    // R3 R5: fast minimum
    set_cfg(1'b1, 3);
    measure(1'b0, 1'b0, 3, 0, 1'b0, 1'b0, 0, "settle");
    measure(1'b1, 1'b1, 3, 0, 1'b0, 1'b0, 0, "R3 R5 fast cc3");

    // R1: upper field only (CC = 128)
    set_cfg(1'b0, 128);
    measure(1'b0, 1'b1, 3, 0, 1'b0, 1'b0, 0, "settle");
    measure(1'b1, 1'b0, 128, 0, 1'b0, 1'b0, 0, "R1 upper field std");

    // R1 R3: full-scale divider, fast
    set_cfg(1'b1, 4095);
    measure(1'b0, 1'b0, 128, 0, 1'b0, 1'b0, 0, "settle");
    measure(1'b1, 1'b1, 4095, 0, 1'b0, 1'b0, 0, "R1 R3 fast cc4095");

    // R9: change mid-period, old timing holds, new applies next
    set_cfg(1'b0, 10);
    measure(1'b0, 1'b1, 4095, 0, 1'b0, 1'b0, 0, "settle");
    measure(1'b1, 1'b0, 10, 0, 1'b1, 1'b1, 7, "R9 old period kept");
    measure(1'b1, 1'b1, 7, 0, 1'b0, 1'b0, 0, "R9 new period applied");

    // R7 with R9: stretch while a change is pending
    measure(1'b1, 1'b1, 7, 6, 1'b1, 1'b0, 20, "R7 R9 stretched old period");
    measure(1'b1, 1'b0, 20, 0, 1'b0, 1'b0, 0, "R9 after stretch");
    measure(1'b1, 1'b0, 20, 13, 1'b0, 1'b0, 0, "R7 stretch std");

    // random mix of modes, dividers and stretch (R2 R3 R4 R5 R7)
    for (int i = 0; i < 16; i++) begin
      bit f;
      int c, s;
      f = 1'($urandom_range(0, 1));
      c = $urandom_range(3, 200);
      s = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 25) : 0;
      set_cfg(f, c);
      measure(1'b0, fast_sel, 20, 0, 1'b0, 1'b0, 0, "settle");
      measure(1'b1, f, c, s, 1'b0, 1'b0, 0, "R2 R3 R7 random");
      if (i == 15) ;
    end

    // R8: disable in the middle of a low phase
    @(negedge clk);
    while (!tick_fall) @(negedge clk);
    repeat (2) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!scl_drive_low, "R8 release after disable", scl_drive_low, 0);
    quiet = 0;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (scl_drive_low || tick_fall || tick_rise || tick_mid) quiet++;
    end
    chk(quiet == 0, "R8 quiet while disabled", quiet, 0);
    set_cfg(1'b0, 5);
    en = 1'b1;
    @(negedge clk);
    chk(tick_fall && scl_drive_low, "R8 restart strobe", {tick_fall, scl_drive_low}, 3);
    measure(1'b1, 1'b0, 5, 0, 1'b0, 1'b0, 0, "R8 R2 after restart");

    // R6: illegal divider, applied mid-period
    set_cfg(1'b0, 2);
    @(negedge clk);
    chk(cfg_err, "R6 error flag", cfg_err, 1);
    repeat (30) @(negedge clk);
    quiet = 0;
    for (int j = 0; j < 60; j++) begin
      @(negedge clk);
      if (scl_drive_low || tick_fall || tick_rise || tick_mid || !cfg_err) quiet++;
    end
    chk(quiet == 0, "R6 held released cc2", quiet, 0);
    set_cfg(1'b1, 0);
    quiet = 0;
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      if (scl_drive_low || tick_fall || !cfg_err) quiet++;
    end
    chk(quiet == 0, "R6 held released cc0", quiet, 0);
    // R1: low field alone decides legality when upper is zero
    set_cfg(1'b1, 3);
    @(negedge clk);
    chk(!cfg_err && tick_fall, "R6 R1 recover legal", {cfg_err, tick_fall}, 1);
    measure(1'b1, 1'b1, 3, 0, 1'b0, 1'b0, 0, "R6 R3 after recovery");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule